// File: doc/BRIEF.md
# Banked RAM address translator

This block turns a 16-bit processor address into a physical RAM address wide enough for 576 KB. That space is a base 64 KB plus eight 64 KB expansion banks. The processor space is cut into four 16 KB pages, selected by address bits 15:14. A banking register chooses a layout and an expansion bank. The layout steers each page either to one 16 KB quarter of the base 64 KB or to one quarter of the chosen expansion bank. Address bits 13:0 pass straight through as the offset within the quarter.

Software loads the register by writing a command byte through a byte-wide port with a write strobe. Bytes that do not carry the banking command marker are ignored. The physical address and an expansion-hit flag are combinational in the current register and the logical address. External logic can use the flag to gate accesses when no expansion memory is fitted.

Top module: `bank_xlate`

## Requirements
- R1: While reset is asserted, and after it is released, the register holds layout 0 and bank 0. In that state paddr_o equals laddr_i zero-extended and exp_hit_o is 0.
- R2: A byte written with wr_en_i high is taken as a banking command only when bits 7 and 6 are both 1. Any other pattern of those two bits leaves the mapping unchanged.
- R3: In an accepted command, bits 5:3 give the expansion bank (0 to 7) and bits 2:0 give the layout (0 to 7). The register loads on the rising clock edge at which the accepted write is presented, and the new mapping is visible from the following cycle.
- R4: The page index is laddr_i[15:14]. The quarter used for pages 0, 1, 2 and 3 is: layout 0 gives 0,1,2,3; layout 1 gives 0,1,2,7; layout 2 gives 4,5,6,7; layout 3 gives 0,3,2,7; layouts 4, 5, 6 and 7 give 0,k,2,3 with k equal to 4, 5, 6 and 7 respectively.
- R5: A quarter q from 0 to 3 maps to physical q*0x4000 plus the offset, so the address lies within 0x00000 to 0x0FFFF.
- R6: A quarter q from 4 to 7 maps to physical 0x10000*(bank+1) + (q-4)*0x4000 plus the offset.
- R7: paddr_o[13:0] always equals laddr_i[13:0].
- R8: exp_hit_o is 1 exactly when the current access maps to a quarter from 4 to 7, that is, when paddr_o is 0x10000 or above.
- R9: With wr_en_i low, wr_data_i has no effect on the mapping, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the command byte |
| wr_data_i | input | 8 | Command byte |
| laddr_i | input | 16 | Logical processor address |
| paddr_o | output | 20 | Physical RAM address |
| exp_hit_o | output | 1 | Access maps to expansion memory |

## Verification
The register assertions assume that wr_en_i and wr_data_i are stable around the rising edge and never unknown. The bench drives them only on falling edges and releases the strobe one cycle later. The address assertions assume laddr_i changes only away from the rising edge, so the combinational output has settled by the time it is sampled. The random stimulus sets roughly half of all bytes to the command marker, so both accepted and ignored writes occur often. It also varies the strobe independently of the data. A directed sweep covers all 64 bank and layout pairs on all four pages.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  localparam int unsigned BANK_W   = 3;
  localparam int unsigned LAYOUT_W = 3;
  localparam int unsigned PAGE_W   = 2;
  localparam int unsigned CMD_W    = 8;

  typedef struct packed {
    logic [BANK_W-1:0]   bank;
    logic [LAYOUT_W-1:0] layout;
  } bank_cfg_t;
endpackage

// File: rtl/bxl_cfg_reg.sv
module bxl_cfg_reg
  import bxl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_data_i,
  output bank_cfg_t        cfg_o
);
  localparam int unsigned FLD_W = BANK_W + LAYOUT_W;

  logic      cmd_ok;
  bank_cfg_t cfg_q;

  // marker: both top bits set
  assign cmd_ok = wr_en_i && (wr_data_i[CMD_W-1:CMD_W-2] == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cmd_ok) cfg_q <= bank_cfg_t'(wr_data_i[FLD_W-1:0]);
  end

  assign cfg_o = cfg_q;

  p_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[CMD_W-1:CMD_W-2] != 2'b11) |=> $stable(cfg_o));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[CMD_W-1:CMD_W-2] == 2'b11)
      |=> (cfg_o.bank == $past(wr_data_i[5:3]) && cfg_o.layout == $past(wr_data_i[2:0])));

  p_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o));
endmodule

// File: rtl/bxl_layout_lut.sv
module bxl_layout_lut
  import bxl_pkg::*;
#(
  localparam int unsigned Q_W = PAGE_W + 1
) (
  input  logic [LAYOUT_W-1:0] layout_i,
  input  logic [PAGE_W-1:0]   page_i,
  output logic [Q_W-1:0]      quarter_o
);
  logic [Q_W-1:0] base_q;
  assign base_q = {1'b0, page_i};

  always_comb begin
    quarter_o = base_q;
    if (layout_i[LAYOUT_W-1]) begin
      // layouts 4..7: page 1 swapped for expansion quarter layout-4
      if (page_i == 2'd1) quarter_o = {1'b1, layout_i[1:0]};
    end else begin
      unique case (layout_i[1:0])
        2'd0: quarter_o = base_q;
        2'd1: if (page_i == 2'd3) quarter_o = 3'd7;
        2'd2: quarter_o = {1'b1, page_i};
        2'd3: begin
          if (page_i == 2'd1) quarter_o = 3'd3;
          if (page_i == 2'd3) quarter_o = 3'd7;
        end
        default: quarter_o = base_q;
      endcase
    end
  end

  always_comb begin
    if (layout_i != 3'd2 && page_i == 2'd0)
      a_page0_base_r4: assert (quarter_o == 3'd0);
    if (layout_i != 3'd2 && page_i == 2'd2)
      a_page2_base_r4: assert (quarter_o == 3'd2);
  end
endmodule

// File: rtl/bxl_addr_form.sv
module bxl_addr_form
  import bxl_pkg::*;
#(
  parameter  int unsigned LA_W  = 16,
  localparam int unsigned Q_W   = PAGE_W + 1,
  localparam int unsigned OFF_W = LA_W - PAGE_W,
  localparam int unsigned HI_W  = BANK_W + 1,
  localparam int unsigned PA_W  = HI_W + PAGE_W + OFF_W
) (
  input  logic [Q_W-1:0]    quarter_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [PA_W-1:0]   paddr_o,
  output logic              exp_hit_o
);
  logic [HI_W-1:0] hi;

  // base 64K sits at 0; expansion bank N sits at 64K*(N+1)
  assign hi        = quarter_i[Q_W-1] ? (HI_W'(bank_i) + HI_W'(1)) : '0;
  assign paddr_o   = {hi, quarter_i[PAGE_W-1:0], offset_i};
  assign exp_hit_o = quarter_i[Q_W-1];
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bxl_pkg::*;
#(
  parameter  int unsigned LA_W  = 16,
  localparam int unsigned OFF_W = LA_W - PAGE_W,
  localparam int unsigned PA_W  = BANK_W + 1 + LA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic [LA_W-1:0]  laddr_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic             exp_hit_o
);
  bank_cfg_t         cfg;
  logic [PAGE_W:0]   quarter;

  bxl_cfg_reg i_cfg_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  bxl_layout_lut i_lut (
    .layout_i  (cfg.layout),
    .page_i    (laddr_i[LA_W-1:OFF_W]),
    .quarter_o (quarter)
  );

  bxl_addr_form #(.LA_W(LA_W)) i_form (
    .quarter_i (quarter),
    .bank_i    (cfg.bank),
    .offset_i  (laddr_i[OFF_W-1:0]),
    .paddr_o   (paddr_o),
    .exp_hit_o (exp_hit_o)
  );

  p_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_hit_o == (paddr_o[PA_W-1:LA_W] != '0));

  p_exp_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_hit_o |-> (paddr_o[PA_W-1:LA_W] == (BANK_W+1)'(cfg.bank) + (BANK_W+1)'(1)));

  p_offset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[OFF_W-1:0] == laddr_i[OFF_W-1:0]);

  p_boot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!exp_hit_o && paddr_o == PA_W'(laddr_i)));
endmodule

// File: tb/test_bank_xlate.sv
module test_bank_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] laddr = '0;
  logic [19:0] paddr;
  logic        exp_hit;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;
  logic [5:0]  m_cfg = '0;  // {bank, layout}

  always #2 clk = ~clk;

  bank_xlate i_bank_xlate (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .laddr_i(laddr), .paddr_o(paddr), .exp_hit_o(exp_hit)
  );

  function automatic int ref_quarter(int lay, int pg);
    case (lay)
      0: return pg;
      1: return (pg == 3) ? 7 : pg;
      2: return pg + 4;
      3: return (pg == 1) ? 3 : (pg == 3) ? 7 : pg;
      default: return (pg == 1) ? lay : pg;
    endcase
  endfunction

  function automatic int ref_paddr(logic [5:0] c, logic [15:0] la);
    int q = ref_quarter(int'(c[2:0]), int'(la[15:14]));
    int off = int'(la[13:0]);
    if (q < 4) return q * 'h4000 + off;
    return 'h10000 * (int'(c[5:3]) + 1) + (q - 4) * 'h4000 + off;
  endfunction

  task automatic probe(logic [15:0] la, string req);
    int exp_pa;
    logic exp_hf;
    laddr = la;
    #1;
    exp_pa = ref_paddr(m_cfg, la);
    exp_hf = (exp_pa >= 'h10000);
    n_chk++;
    if (int'(paddr) != exp_pa || exp_hit != exp_hf) begin
      n_bad++;
      $display("FAIL %s cfg=%02h la=%04h paddr=%05h hit=%0b expected paddr=%05h hit=%0b",
               req, m_cfg, la, paddr, exp_hit, exp_pa, exp_hf);
    end
  endtask

  task automatic do_write(logic en, logic [7:0] b);
    @(negedge clk);
    wr_en = en; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (en && b[7:6] == 2'b11) m_cfg = b[5:0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: during reset, then a valid write under reset must not take
    @(negedge clk);
    probe(16'hC123, "R1"); probe(16'h4000, "R1");
    wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    probe(16'hFFFF, "R1"); probe(16'h8ABC, "R1"); probe(16'h0000, "R1");

    // R3/R4/R5/R6/R7: sweep every bank and layout on every page
    for (int c = 0; c < 64; c++) begin
      do_write(1'b1, 8'hC0 | 8'(c));
      for (int p = 0; p < 4; p++) begin
        probe(16'(p << 14) | 16'h0000, "R4");
        probe(16'(p << 14) | 16'h3FFF, "R6");
        probe(16'(p << 14) | 16'h1A5C, "R7");
      end
    end

    // R2: top bits 00/01/10 ignored
    do_write(1'b1, 8'hC2);
    probe(16'h4321, "R3");
    do_write(1'b1, 8'h3F); probe(16'h4321, "R2"); probe(16'hC000, "R2");
    do_write(1'b1, 8'h7D); probe(16'h4321, "R2");
    do_write(1'b1, 8'hBB); probe(16'h0321, "R2"); probe(16'h8321, "R8");

    // R9: strobe low with a valid command byte
    do_write(1'b0, 8'hC7); probe(16'h4000, "R9"); probe(16'hFFFF, "R9");

    // R8: base-only layout still signals no hit at top of space
    do_write(1'b1, 8'hF8); probe(16'hFFFF, "R8");

    // random mix
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b = 8'($urandom);
      if ($urandom_range(1, 0) == 1) b[7:6] = 2'b11;
      do_write($urandom_range(3, 0) != 0, b);
      for (int k = 0; k < 3; k++) probe(16'($urandom), "R2");
    end

    finish_run();
  end
endmodule